// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the storage and arithmetic half of a small processor built around one shared data bus. It holds a program counter, an instruction register, a memory address register, a memory data register, a bank of general registers, an ALU staging register on the A side and a result register behind the ALU. It contains no sequencer. An external controller asserts a set of enable strobes in every clock, and the block performs exactly those register transfers. Each storage element has a strobe that puts its contents on the bus and a strobe that loads it from the bus at the next rising edge. An extra source strobe drives a word supplied from outside, so a controller or a test can inject constants.

The ALU takes its B operand straight from the bus. Its A operand is either the staging register or the constant 4, so the program counter can be advanced without loading the staging register first. A result can return to the bus only after it has been captured in the result register. A word-addressed memory model with a fixed, parameterised latency sits behind the address and data registers. A read or write request raises a one-cycle completion pulse. On a read, the data is loaded into the memory data register at the end of that pulse cycle, so a controller that waits for the pulse can put the data on the bus in the next step. A typical instruction of two words (opcode and mode, then an operand or an address) takes a few such steps per word.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register and general register clears to 0 and `mfc` clears to 0. With no source strobe asserted, `bus` reads 0.
- R2: When exactly one source strobe is asserted, `bus` shows that source in the same cycle. The sources are `ext_data`, PC, IR, MDR, Z and general register k when `gpr_out[k]` is set. At most one source strobe may be high in any cycle.
- R3: Each load strobe (`pc_in`, `ir_in`, `mar_in`, `mdr_in`, `y_in`, `gpr_in[k]`) copies `bus` into its register at the rising edge. Several registers may load the same bus word in one cycle. A register whose load strobe is low keeps its value.
- R4: The ALU A operand is the constant 4 when `sel4`=1 and the Y register when `sel4`=0. The B operand is `bus`. When `z_in` is set, Z captures the result at the edge.
- R5: `alu_op` encodes 0 = A+B, 1 = A-B, 2 = A AND B and 3 = A OR B. Arithmetic wraps modulo 2^32.
- R6: Z changes only on an edge where `z_in` is set, so an ALU result reaches the bus only through `z_out`.
- R7: A read requested with `mem_rd` in cycle c, with MAR = a, makes `mfc` high in cycle c+LAT+1 and only in that cycle. MDR equals memory word a from cycle c+LAT+2. LAT is 1 to 3.
- R8: A write requested with `mem_wr` in cycle c stores MDR at word MAR of memory at that edge. It raises `mfc` with the same timing as a read and leaves MDR unchanged.
- R9: A request made while an earlier request has not yet raised `mfc` (cycles c+1 to c+LAT) is ignored. It produces no additional `mfc` pulse and leaves memory unchanged.
- R10: The memory has 256 words, addressed by MAR bits [7:0]. Higher MAR bits are ignored, so address 0x105 selects word 5.
- R11: In the `mfc` cycle of a read, the returned memory word takes priority over `mdr_in` for loading MDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_data | input | 32 | Externally supplied word for the bus |
| ext_out | input | 1 | Drive `ext_data` onto the bus |
| pc_out | input | 1 | Drive PC onto the bus |
| pc_in | input | 1 | Load PC from the bus |
| ir_out | input | 1 | Drive IR onto the bus |
| ir_in | input | 1 | Load IR from the bus |
| mar_in | input | 1 | Load MAR from the bus |
| mdr_out | input | 1 | Drive MDR onto the bus |
| mdr_in | input | 1 | Load MDR from the bus |
| y_in | input | 1 | Load Y from the bus |
| sel4 | input | 1 | ALU A operand: 1 = constant 4, 0 = Y |
| alu_op | input | 2 | ALU function code (see R5) |
| z_in | input | 1 | Load Z with the ALU result |
| z_out | input | 1 | Drive Z onto the bus |
| gpr_out | input | 8 | Drive general register k onto the bus |
| gpr_in | input | 8 | Load general register k from the bus |
| mem_rd | input | 1 | Request a memory read at MAR |
| mem_wr | input | 1 | Request a memory write of MDR at MAR |
| mfc | output | 1 | Memory function complete, one-cycle pulse |
| bus | output | 32 | Current value of the shared bus |

## Verification
The assertions rely on the controller keeping its strobes legal. Each cycle has at most one bus source, and `mem_rd` and `mem_wr` are never both high. The stimulus drives every strobe from a single task that clears all of them before it sets the few a step needs, so these conditions hold throughout. Memory words are read back only after they have been written, because the model has no reset contents and an unwritten word is undefined.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  localparam int unsigned INC_STEP = 4;

endpackage

// File: rtl/sbus_gpr_bank.sv
module sbus_gpr_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  rd_en,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs   [N];
  logic [DW-1:0] masked [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[i] <= '0;
      else if (wr_en[i]) regs[i] <= wdata;
    end

    assign masked[i] = rd_en[i] ? regs[i] : '0;

    // R3: an unselected register keeps its contents
    a_r3_gpr_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en[i] |=> $stable(regs[i]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N; k++) rdata = rdata | masked[k];
  end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          sel_const,
  input  logic [DW-1:0] y_val,
  input  logic [DW-1:0] b_val,
  input  alu_op_e       op,
  output logic [DW-1:0] result
);

  logic [DW-1:0] a_val;

  assign a_val = sel_const ? DW'(INC_STEP) : y_val;

  always_comb begin
    unique case (op)
      ALU_ADD: result = a_val + b_val;
      ALU_SUB: result = a_val - b_val;
      ALU_AND: result = a_val & b_val;
      ALU_OR:  result = a_val | b_val;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/sbus_mem_model.sv
module sbus_mem_model #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LAT   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic                     wr_req,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     mfc,
  output logic                     rd_done
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          is_rd_q;
  logic          mfc_q;
  logic          idle;
  logic          accept;

  assign idle   = (cnt_q == '0);
  assign accept = idle && (rd_req || wr_req);

  // storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_req && idle) mem[addr] <= wdata;
    rdata <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      is_rd_q <= 1'b0;
      mfc_q   <= 1'b0;
    end else begin
      mfc_q <= (cnt_q == CW'(1));
      if (accept) begin
        cnt_q   <= CW'(LAT);
        addr_q  <= addr;
        is_rd_q <= rd_req;
      end else if (!idle) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mfc     = mfc_q;
  assign rd_done = mfc_q && is_rd_q;

  // R7: completion is a single-cycle pulse
  a_r7_mfc_pulse: assert property (@(posedge clk) disable iff (rst)
    mfc |=> !mfc);

  // R9: no completion can follow within one cycle of an accepted request
  a_r9_no_early_mfc: assert property (@(posedge clk) disable iff (rst)
    accept |=> !mfc);

  // R8: the controller never requests a read and a write together
  a_r8_rdwr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned NGPR      = 8,
  parameter int unsigned MEM_DEPTH = 256,
  parameter int unsigned LAT       = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   ext_data,
  input  logic            ext_out,
  input  logic            pc_out,
  input  logic            pc_in,
  input  logic            ir_out,
  input  logic            ir_in,
  input  logic            mar_in,
  input  logic            mdr_out,
  input  logic            mdr_in,
  input  logic            y_in,
  input  logic            sel4,
  input  logic [1:0]      alu_op,
  input  logic            z_in,
  input  logic            z_out,
  input  logic [NGPR-1:0] gpr_out,
  input  logic [NGPR-1:0] gpr_in,
  input  logic            mem_rd,
  input  logic            mem_wr,
  output logic            mfc,
  output logic [DW-1:0]   bus
);

  localparam int unsigned AW   = $clog2(MEM_DEPTH);
  localparam int unsigned NSRC = NGPR + 5;

  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, y_q, z_q;
  logic [DW-1:0] gpr_rdata;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] mem_rdata;
  logic          mem_rd_done;
  logic [NSRC-1:0] src_en;

  assign src_en = {ext_out, pc_out, ir_out, mdr_out, z_out, gpr_out};

  // shared bus: OR of gated sources
  always_comb begin
    bus = gpr_rdata;
    if (ext_out) bus = bus | ext_data;
    if (pc_out)  bus = bus | pc_q;
    if (ir_out)  bus = bus | ir_q;
    if (mdr_out) bus = bus | mdr_q;
    if (z_out)   bus = bus | z_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      y_q   <= '0;
      z_q   <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_in)  pc_q  <= bus;
      if (ir_in)  ir_q  <= bus;
      if (mar_in) mar_q <= bus;
      if (y_in)   y_q   <= bus;
      if (z_in)   z_q   <= alu_res;
      if (mem_rd_done) mdr_q <= mem_rdata;
      else if (mdr_in) mdr_q <= bus;
    end
  end

  sbus_gpr_bank #(.DW(DW), .N(NGPR)) u_gpr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (gpr_in),
    .wdata (bus),
    .rd_en (gpr_out),
    .rdata (gpr_rdata)
  );

  sbus_alu #(.DW(DW)) u_alu (
    .sel_const (sel4),
    .y_val     (y_q),
    .b_val     (bus),
    .op        (alu_op_e'(alu_op)),
    .result    (alu_res)
  );

  sbus_mem_model #(.DW(DW), .DEPTH(MEM_DEPTH), .LAT(LAT)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (mem_rd),
    .wr_req  (mem_wr),
    .addr    (mar_q[AW-1:0]),
    .wdata   (mdr_q),
    .rdata   (mem_rdata),
    .mfc     (mfc),
    .rd_done (mem_rd_done)
  );

  // R2: at most one bus source per cycle
  a_r2_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));

  // R1: an undriven bus reads zero
  a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |-> (bus == '0));

  // R3: PC holds without its load strobe
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_in |=> $stable(pc_q));

  // R4: increment path adds the constant to the bus word
  a_r4_incr_path: assert property (@(posedge clk) disable iff (rst)
    (z_in && sel4 && alu_op == 2'd0) |=> (z_q == $past(bus) + DW'(INC_STEP)));

  // R6: Z changes only when loaded
  a_r6_z_hold: assert property (@(posedge clk) disable iff (rst)
    !z_in |=> $stable(z_q));

  // R11: returned read data wins over a bus load of MDR
  a_r11_mdr_mem_first: assert property (@(posedge clk) disable iff (rst)
    mem_rd_done |=> (mdr_q == $past(mem_rdata)));

endmodule

// File: tb/sbus_datapath_bench.sv
module sbus_datapath_bench;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ext_data;
  logic        ext_out, pc_out, pc_in, ir_out, ir_in, mar_in;
  logic        mdr_out, mdr_in, y_in, sel4, z_in, z_out;
  logic [1:0]  alu_op;
  logic [7:0]  gpr_out, gpr_in;
  logic        mem_rd, mem_wr;
  logic        mfc;
  logic [31:0] bus;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sbus_datapath #(.LAT(LAT)) u_sbus_datapath (
    .clk(clk), .rst(rst), .ext_data(ext_data), .ext_out(ext_out),
    .pc_out(pc_out), .pc_in(pc_in), .ir_out(ir_out), .ir_in(ir_in),
    .mar_in(mar_in), .mdr_out(mdr_out), .mdr_in(mdr_in), .y_in(y_in),
    .sel4(sel4), .alu_op(alu_op), .z_in(z_in), .z_out(z_out),
    .gpr_out(gpr_out), .gpr_in(gpr_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mfc(mfc), .bus(bus)
  );

  task automatic clr();
    ext_data = '0; ext_out = 0; pc_out = 0; pc_in = 0; ir_out = 0; ir_in = 0;
    mar_in = 0; mdr_out = 0; mdr_in = 0; y_in = 0; sel4 = 0; alu_op = 0;
    z_in = 0; z_out = 0; gpr_out = '0; gpr_in = '0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // source codes: 0 PC, 1 IR, 2 MDR, 3 Z, 4+k general register k
  task automatic peek(input int src, output logic [31:0] v);
    clr();
    case (src)
      0: pc_out = 1;
      1: ir_out = 1;
      2: mdr_out = 1;
      3: z_out = 1;
      default: gpr_out[src-4] = 1;
    endcase
    #1 v = bus;
    clr();
  endtask

  task automatic load_mar(input logic [31:0] v);
    clr(); ext_data = v; ext_out = 1; mar_in = 1; tick(); clr();
  endtask

  task automatic load_mdr(input logic [31:0] v);
    clr(); ext_data = v; ext_out = 1; mdr_in = 1; tick(); clr();
  endtask

  // from cycle c+1 after a request, follow mfc to c+LAT+1 then step past it
  task automatic follow_mfc(input string req);
    for (int i = 1; i <= LAT + 1; i++) begin
      check(req, {31'd0, mfc}, {31'd0, (i == LAT + 1)});
      if (i <= LAT) tick();
    end
    tick();
    check(req, {31'd0, mfc}, 32'd0);
  endtask

  task automatic mem_write(input logic [31:0] a, input logic [31:0] d);
    load_mar(a);
    load_mdr(d);
    mem_wr = 1; tick(); clr();
    follow_mfc("R8 write mfc timing");
  endtask

  task automatic mem_read(input logic [31:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    load_mar(a);
    mem_rd = 1; tick(); clr();
    follow_mfc("R7 read mfc timing");
    peek(2, v);
    check(req, v, exp);
  endtask

  function automatic logic [31:0] alu_ref(input logic [31:0] a, input logic [31:0] b, input int op);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [31:0] mem_pat(input int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0203) ^ 32'h0000_0F0F;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, v2;
    logic [31:0] ops [6];
    ops[0] = 32'h0; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h7FFF_FFFF;
    ops[3] = 32'h1; ops[4] = 32'h1234_5678; ops[5] = 32'h8000_0000;

    clr();
    rst = 1;
    repeat (3) tick();
    rst = 0;

    // R1: reset state
    for (int s = 0; s < 12; s++) begin
      peek(s, v);
      check("R1 reset register value", v, 32'd0);
    end
    #1 check("R1 idle bus", bus, 32'd0);
    check("R1 mfc after reset", {31'd0, mfc}, 32'd0);

    // R3/R2: load each general register, read all back
    for (int k = 0; k < 8; k++) begin
      clr(); ext_data = 32'hC0DE_0000 + k * 32'h0011_1111; ext_out = 1; gpr_in[k] = 1;
      tick(); clr();
    end
    for (int k = 0; k < 8; k++) begin
      peek(4 + k, v);
      check("R2 general register on bus", v, 32'hC0DE_0000 + k * 32'h0011_1111);
    end

    // R3: one bus word into several registers; R2: register to register move
    clr(); ext_data = 32'hFACE_B00C; ext_out = 1; pc_in = 1; ir_in = 1; tick(); clr();
    peek(0, v); check("R3 multi-load PC", v, 32'hFACE_B00C);
    peek(1, v); check("R3 multi-load IR", v, 32'hFACE_B00C);
    peek(7, v); check("R3 unselected R3 holds", v, 32'hC0DE_0000 + 3 * 32'h0011_1111);
    clr(); gpr_out[5] = 1; pc_in = 1; tick(); clr();
    peek(0, v); check("R2 R5 to PC transfer", v, 32'hC0DE_0000 + 5 * 32'h0011_1111);

    // R4/R5: ALU sweep over operands, functions and the A-side select
    foreach (ops[yi]) begin
      clr(); ext_data = ops[yi]; ext_out = 1; y_in = 1; tick(); clr();
      foreach (ops[bi]) begin
        for (int op = 0; op < 4; op++) begin
          for (int s4 = 0; s4 < 2; s4++) begin
            clr(); ext_data = ops[bi]; ext_out = 1; sel4 = s4[0]; alu_op = op[1:0]; z_in = 1;
            tick(); clr();
            peek(3, v);
            check(s4 ? "R4 constant A operand" : "R5 Y operand function",
                  v, alu_ref(s4 ? 32'd4 : ops[yi], ops[bi], op));
          end
        end
      end
    end

    // R6: Z holds while ALU inputs change
    peek(3, v);
    clr(); ext_data = 32'h1357_9BDF; ext_out = 1; y_in = 1; tick(); clr();
    clr(); ext_data = 32'h0246_8ACE; ext_out = 1; alu_op = 2'd0; tick(); clr();
    peek(3, v2); check("R6 Z holds without z_in", v2, v);

    // R4: PC increment through Z and back
    clr(); pc_out = 1; sel4 = 1; alu_op = 2'd0; z_in = 1; tick(); clr();
    clr(); z_out = 1; pc_in = 1; tick(); clr();
    peek(0, v); check("R4 PC advanced by four", v, 32'hC0DE_0000 + 5 * 32'h0011_1111 + 4);

    // R7/R8: write then read back a range of words
    for (int a = 0; a < 32; a++) mem_write(a, mem_pat(a));
    peek(2, v); check("R8 write leaves MDR", v, mem_pat(31));
    for (int a = 0; a < 32; a++) mem_read(a, mem_pat(a), "R7 read data");

    // R10: high MAR bits ignored
    mem_write(32'h0000_0105, 32'hDEAD_0105);
    mem_read(32'd5, 32'hDEAD_0105, "R10 address wrap");
    mem_write(32'h0000_00FF, 32'hBEEF_00FF);
    mem_read(32'hFFFF_FFFF, 32'hBEEF_00FF, "R10 top word");

    // R9: write issued while a read is outstanding is ignored
    load_mar(32'd9);
    mem_rd = 1; tick(); clr();
    mem_wr = 1; tick(); clr();
    for (int i = 2; i <= LAT + 1; i++) begin
      check("R9 mfc of first request", {31'd0, mfc}, {31'd0, (i == LAT + 1)});
      if (i <= LAT) tick();
    end
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R9 no extra mfc", {31'd0, mfc}, 32'd0);
    end
    peek(2, v); check("R9 read data", v, mem_pat(9));
    mem_read(32'd9, mem_pat(9), "R9 memory unchanged");

    // R11: memory return beats mdr_in in the mfc cycle
    load_mar(32'd17);
    mem_rd = 1; tick(); clr();
    repeat (LAT) tick();
    check("R11 in mfc cycle", {31'd0, mfc}, 32'd1);
    ext_data = 32'h0BAD_0BAD; ext_out = 1; mdr_in = 1; tick(); clr();
    peek(2, v); check("R11 MDR priority", v, mem_pat(17));

    // R1: reset in mid-operation
    load_mar(32'd3); mem_rd = 1; tick(); clr();
    rst = 1; tick(); rst = 0;
    for (int i = 0; i < LAT + 2; i++) begin
      check("R1 reset cancels mfc", {31'd0, mfc}, 32'd0);
      tick();
    end
    peek(0, v); check("R1 PC after reset", v, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule